// File: doc/BRIEF.md
# ULPI Link Power-Up Sequencer

This block sits on the link side of a ULPI transceiver interface and takes the bus from power-on to a usable idle state. It turns on the transceiver's chip select and then ignores the ULPI inputs for a fixed window, because the pads can hold any level until the transceiver's own power-on reset has run. After that window it waits for the transceiver to take DIR high and then drop it. A falling DIR means the PHY clock is stable and the link may own the bus.

Once it owns the bus, the sequencer drives an idle bus with STP low. It then sends a register write that sets the reset bit of the function control register. It waits for the transceiver to turn the bus around and report an RXCMD. When DIR falls again after that report, it raises `ready` and keeps it high. Two timeout counters report a PHY that never releases DIR and a PHY that never answers the reset. A DIR rise in the middle of the write aborts the write, and the write is retried.

All logic runs on the 60 MHz ULPI clock and uses a synchronous active-high reset.

Top module: `ulpi_pwrup_seq`

## Requirements
- R1: While `rst` is high, `chip_sel`, `data_oe`, `stp` and `ready` are low. On the first clock edge with `rst` low, `chip_sel` goes high, and it stays high.
- R2: For the first BLANK_CYC cycles after chip select turns on, `dir`, `nxt` and `data_in` have no effect. `data_oe` and `stp` stay low whatever those inputs do, including a high-then-low DIR pattern.
- R3: `data_oe` is never high in a cycle where `dir` is high, and it drops in the same cycle that `dir` rises. After `dir` falls, `data_oe` stays low for that first low cycle (the turnaround) and can rise only in the following cycle.
- R4: The blank window must end, then `dir` must be seen high and then low. After that, the link drives the register-write TXCMD 8'h84 on `data_out`: bits 7:6 = 2'b10 (register write) and bits 5:0 = 6'h04 (function control address). It holds that byte until it samples `nxt` high.
- R5: In the cycle after `nxt` is sampled high with the command on the bus, `data_out` is 8'h20 (reset bit set). In the next cycle `stp` is high with `data_out` 8'h00, and `stp` is high for that cycle only. After that the link keeps driving 8'h00 with `stp` low.
- R6: If `dir` rises during the command, data or stop cycle, the write is aborted. `data_oe` drops in that cycle and no stop pulse is issued. Once `dir` is low again and the turnaround cycle has passed, the command byte 8'h84 is driven again.
- R7: After the write, an RXCMD is a cycle with `dir` high for the second consecutive cycle and `nxt` low. After an RXCMD, `ready` goes high in the cycle after `dir` falls. It then stays high until reset.
- R8: If `dir` has not been seen falling after the blank window within DIR_TMO cycles of chip select turning on, `err_dir_tmo` goes high and stays high. `ready` stays low and no command is driven.
- R9: If no RXCMD arrives within RX_TMO cycles after the stop cycle, `err_rx_tmo` goes high and stays high, and `ready` stays low.
- R10: `stp` is low in every cycle except the stop cycle of the reset write. In every cycle where the link drives the bus and no write is in progress, `data_out` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz ULPI clock from the transceiver |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Bus direction from the PHY; high means the PHY drives DATA |
| nxt | input | 1 | PHY throttle and handshake strobe |
| data_in | input | 8 | DATA bus as seen by the link |
| chip_sel | output | 1 | Active-high transceiver enable |
| stp | output | 1 | Stop strobe to the PHY |
| data_out | output | 8 | Byte the link drives on DATA |
| data_oe | output | 1 | Output enable for the link's DATA pads |
| ready | output | 1 | Bus initialized and idle |
| err_dir_tmo | output | 1 | PHY never released DIR in time |
| err_rx_tmo | output | 1 | No RXCMD followed the reset write |

## Verification
If the sequencer's state were wrong, it would show at the pads within one or two ULPI cycles. It could drive the bus while DIR is high, drive too early after a DIR fall, put the wrong byte in a write phase, pulse STP at the wrong time, or raise `ready` without the RXCMD handshake. The stimulus randomizes the garbage seen during the blank window, the NXT latency, the idle gap before the RXCMD, and whether and where the write is aborted. The outputs are compared on every cycle, so any of these faults appears as a miscompare in the first cycle it occurs. A fault in a timeout counter shows up as an error flag that rises too early or never rises, tested a few cycles on each side of its limit.

// File: rtl/ulpi_pwrup_pkg.sv
package ulpi_pwrup_pkg;

    typedef logic [7:0] ulpi_byte_t;

    typedef enum logic [3:0] {
        PU_OFF,
        PU_BLANK,
        PU_WAIT_HI,
        PU_WAIT_LO,
        PU_CMD,
        PU_DATA,
        PU_STOP,
        PU_WAIT_RX,
        PU_RX_END,
        PU_READY,
        PU_FAIL_DIR,
        PU_FAIL_RX
    } pu_state_e;

    // Address of the function control register and its reset bit value
    localparam logic [5:0] FUNC_CTRL_ADDR = 6'h04;
    localparam ulpi_byte_t RESET_BIT_VAL  = 8'h20;
    localparam ulpi_byte_t IDLE_BYTE      = 8'h00;

    // What the link wants on its pads in a given state (before DIR gating)
    typedef struct packed {
        logic       oe_req;
        logic       stp;
        ulpi_byte_t data;
    } link_drive_t;

    function automatic ulpi_byte_t reg_write_cmd(input logic [5:0] addr);
        return {2'b10, addr};
    endfunction

    function automatic link_drive_t drive_for(input pu_state_e s);
        link_drive_t d;
        d = '{oe_req: 1'b0, stp: 1'b0, data: IDLE_BYTE};
        case (s)
            PU_CMD:     d = '{oe_req: 1'b1, stp: 1'b0, data: reg_write_cmd(FUNC_CTRL_ADDR)};
            PU_DATA:    d = '{oe_req: 1'b1, stp: 1'b0, data: RESET_BIT_VAL};
            PU_STOP:    d = '{oe_req: 1'b1, stp: 1'b1, data: IDLE_BYTE};
            PU_WAIT_RX,
            PU_RX_END,
            PU_READY:   d = '{oe_req: 1'b1, stp: 1'b0, data: IDLE_BYTE};
            default:    d = '{oe_req: 1'b0, stp: 1'b0, data: IDLE_BYTE};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ulpi_tmo_ctr.sv
module ulpi_tmo_ctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Counts consecutive cycles with run high; clears as soon as run drops
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/ulpi_turnaround.sv
module ulpi_turnaround (
    input  logic clk,
    input  logic rst,
    input  logic dir,
    output logic bus_free,
    output logic rx_slot
);
    logic dir_q;

    // The PHY is assumed to own the bus coming out of reset
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b1;
        end else begin
            dir_q <= dir;
        end
    end

    // Link may drive only after a full low cycle; release is immediate
    assign bus_free = !dir && !dir_q;
    // PHY data is valid from the second cycle of a DIR-high stretch
    assign rx_slot  = dir && dir_q;

endmodule

// File: rtl/ulpi_pwrup_seq.sv
module ulpi_pwrup_seq
    import ulpi_pwrup_pkg::*;
#(
    parameter int BLANK_CYC = 16,
    parameter int DIR_TMO   = 64,
    parameter int RX_TMO    = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir,
    input  logic       nxt,
    input  logic [7:0] data_in,
    output logic       chip_sel,
    output logic       stp,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       ready,
    output logic       err_dir_tmo,
    output logic       err_rx_tmo
);
    pu_state_e   state, state_nx;
    link_drive_t drv;
    logic        bus_free, rx_slot;
    logic        blank_run, dir_run, rx_run;
    logic        blank_done, dir_late, rx_late;

    ulpi_turnaround u_turn (
        .clk      (clk),
        .rst      (rst),
        .dir      (dir),
        .bus_free (bus_free),
        .rx_slot  (rx_slot)
    );

    assign blank_run = (state == PU_BLANK);
    assign dir_run   = (state == PU_BLANK) || (state == PU_WAIT_HI) || (state == PU_WAIT_LO);
    assign rx_run    = (state == PU_WAIT_RX);

    ulpi_tmo_ctr #(.LIMIT(BLANK_CYC)) u_blank (
        .clk (clk), .rst (rst), .run (blank_run), .expired (blank_done)
    );
    ulpi_tmo_ctr #(.LIMIT(DIR_TMO)) u_dir_tmo (
        .clk (clk), .rst (rst), .run (dir_run), .expired (dir_late)
    );
    ulpi_tmo_ctr #(.LIMIT(RX_TMO)) u_rx_tmo (
        .clk (clk), .rst (rst), .run (rx_run), .expired (rx_late)
    );

    always_comb begin
        state_nx = state;
        case (state)
            PU_OFF:     state_nx = PU_BLANK;
            PU_BLANK:   if (dir_late) state_nx = PU_FAIL_DIR;
                        else if (blank_done) state_nx = PU_WAIT_HI;
            PU_WAIT_HI: if (dir_late) state_nx = PU_FAIL_DIR;
                        else if (dir) state_nx = PU_WAIT_LO;
            PU_WAIT_LO: if (!dir) state_nx = PU_CMD;
                        else if (dir_late) state_nx = PU_FAIL_DIR;
            PU_CMD:     if (bus_free && nxt) state_nx = PU_DATA;
            PU_DATA:    state_nx = dir ? PU_CMD : PU_STOP;
            PU_STOP:    state_nx = dir ? PU_CMD : PU_WAIT_RX;
            PU_WAIT_RX: if (rx_slot && !nxt) state_nx = PU_RX_END;
                        else if (rx_late) state_nx = PU_FAIL_RX;
            PU_RX_END:  if (!dir) state_nx = PU_READY;
            default:    state_nx = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PU_OFF;
        end else begin
            state <= state_nx;
        end
    end

    assign drv         = drive_for(state);
    assign data_oe     = drv.oe_req && bus_free;
    assign stp         = drv.stp && bus_free;
    assign data_out    = drv.data;
    assign chip_sel    = (state != PU_OFF);
    assign ready       = (state == PU_READY);
    assign err_dir_tmo = (state == PU_FAIL_DIR);
    assign err_rx_tmo  = (state == PU_FAIL_RX);

    // R3
    oe_dir_chk: assert property (@(posedge clk) disable iff (rst) dir |-> !data_oe);
    // R3
    oe_turn_chk: assert property (@(posedge clk) disable iff (rst) $rose(data_oe) |-> !$past(dir));
    // R10
    stp_idle_chk: assert property (@(posedge clk) disable iff (rst) stp |-> (data_oe && data_out == IDLE_BYTE));
    // R5
    stp_pulse_chk: assert property (@(posedge clk) disable iff (rst) stp |=> !stp);
    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst) ready |=> ready);
    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (rst) (err_dir_tmo || err_rx_tmo) |-> !ready);
    // R2
    blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PU_BLANK && !blank_done && !dir_late && !$stable(data_in)) |=> (state == PU_BLANK));

endmodule

// File: tb/ulpi_pwrup_seq_tb.sv
module ulpi_pwrup_seq_tb_top;

    localparam int BLANK = 16;
    localparam int DTMO  = 64;
    localparam int RTMO  = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir = 1'b0;
    logic       nxt = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       chip_sel, stp, data_oe, ready, err_dir_tmo, err_rx_tmo;
    logic [7:0] data_out;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    ulpi_pwrup_seq #(.BLANK_CYC(BLANK), .DIR_TMO(DTMO), .RX_TMO(RTMO)) dut_i (
        .clk (clk), .rst (rst), .dir (dir), .nxt (nxt), .data_in (data_in),
        .chip_sel (chip_sel), .stp (stp), .data_out (data_out), .data_oe (data_oe),
        .ready (ready), .err_dir_tmo (err_dir_tmo), .err_rx_tmo (err_rx_tmo)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_txcmd();
        return 8'h80 | 8'h04;
    endfunction

    function automatic logic [7:0] exp_reset_byte();
        return 8'h01 << 5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #4;
    endtask

    task automatic settle();
        #4;
    endtask

    task automatic do_reset();
        rst = 1'b1; dir = 1'b0; nxt = 1'b0; data_in = 8'h00;
        repeat (3) next_cycle();
        settle();
        chk("R1 chip_sel in reset", chip_sel, 0);
        chk("R1 oe in reset", data_oe, 0);
        chk("R1 stp in reset", stp, 0);
        chk("R1 ready in reset", ready, 0);
        next_cycle();
        rst = 1'b0;
        next_cycle();
        settle();
        chk("R1 chip_sel after release", chip_sel, 1);
    endtask

    // Garbage during blank, then a clean DIR high stretch
    task automatic blank_and_dir_high();
        for (int i = 0; i < BLANK - 5; i++) begin
            next_cycle();
            dir = 1'($urandom); nxt = 1'($urandom); data_in = 8'($urandom);
            settle();
            chk("R2 oe during blank", data_oe, 0);
            chk("R10 stp during blank", stp, 0);
        end
        next_cycle();
        dir = 1'b1; nxt = 1'b0;
        settle();
        chk("R3 oe while dir high", data_oe, 0);
        for (int h = 0; h < 6 + int'($urandom % 6); h++) begin
            next_cycle();
            settle();
            chk("R3 oe while dir high", data_oe, 0);
            chk("R1 chip_sel held", chip_sel, 1);
        end
    endtask

    // Abort: dir rises for two cycles, falls, turnaround, command again
    task automatic do_abort();
        next_cycle();
        dir = 1'b1; nxt = 1'b0;
        settle();
        chk("R6 oe drops on dir rise", data_oe, 0);
        chk("R6 no stp on abort", stp, 0);
        next_cycle();
        settle();
        chk("R6 oe while aborted", data_oe, 0);
        next_cycle();
        dir = 1'b0;
        settle();
        chk("R3 turnaround after abort", data_oe, 0);
        next_cycle();
        settle();
        chk("R6 retry oe", data_oe, 1);
        chk("R6 retry command byte", data_out, exp_txcmd());
    endtask

    task automatic handshake();
        next_cycle();
        nxt = 1'b1;
        settle();
        chk("R4 command before nxt", data_out, exp_txcmd());
        next_cycle();
        nxt = 1'b0;
        settle();
        chk("R5 data byte", data_out, exp_reset_byte());
        chk("R5 data oe", data_oe, 1);
        chk("R10 stp in data", stp, 0);
    endtask

    task automatic bring_to_wait_rx(input int abort_mode);
        do_reset();
        blank_and_dir_high();
        next_cycle();
        dir = 1'b0;
        settle();
        chk("R3 turnaround on first fall", data_oe, 0);
        next_cycle();
        settle();
        chk("R4 oe for command", data_oe, 1);
        chk("R4 command byte", data_out, exp_txcmd());
        chk("R10 stp in command", stp, 0);
        if (abort_mode == 1) do_abort();
        for (int l = 0; l < int'($urandom % 4); l++) begin
            next_cycle();
            settle();
            chk("R4 command held", data_out, exp_txcmd());
        end
        handshake();
        if (abort_mode == 2) begin
            do_abort();
            handshake();
        end
        next_cycle();
        settle();
        chk("R5 stp pulse", stp, 1);
        chk("R5 stop byte", data_out, 8'h00);
        next_cycle();
        settle();
        chk("R5 stp single cycle", stp, 0);
        chk("R10 idle byte", data_out, 8'h00);
        chk("R10 idle oe", data_oe, 1);
    endtask

    task automatic finish_rx();
        for (int k = 0; k < int'($urandom % 4); k++) begin
            next_cycle();
            settle();
            chk("R7 no early ready", ready, 0);
            chk("R10 idle drive", data_out, 8'h00);
        end
        next_cycle();
        dir = 1'b1; nxt = 1'b0; data_in = 8'($urandom);
        settle();
        chk("R3 oe released on dir rise", data_oe, 0);
        next_cycle();
        data_in = 8'($urandom);
        settle();
        chk("R7 no ready during rxcmd", ready, 0);
        next_cycle();
        dir = 1'b0;
        settle();
        chk("R7 no ready in turnaround", ready, 0);
        chk("R3 oe in turnaround", data_oe, 0);
        next_cycle();
        settle();
        chk("R7 ready after rxcmd", ready, 1);
        chk("R10 idle after ready", data_out, 8'h00);
        for (int q = 0; q < 3; q++) begin
            next_cycle();
            nxt = 1'($urandom);
            settle();
            chk("R7 ready held", ready, 1);
            chk("R9 no rx error", err_rx_tmo, 0);
        end
    endtask

    task automatic run_dir_timeout(input bit stuck_high);
        do_reset();
        dir = stuck_high;
        for (int c = 2; c <= DTMO + 3; c++) begin
            next_cycle();
            nxt = 1'($urandom); data_in = 8'($urandom);
            settle();
            chk("R8 no drive without dir fall", data_oe, 0);
            if (c == DTMO - 3) chk("R8 error not early", err_dir_tmo, 0);
        end
        chk("R8 dir timeout flag", err_dir_tmo, 1);
        chk("R8 ready low on error", ready, 0);
    endtask

    task automatic run_rx_timeout();
        bring_to_wait_rx(0);
        for (int k = 2; k <= RTMO + 3; k++) begin
            next_cycle();
            settle();
            if (k == RTMO - 3) chk("R9 error not early", err_rx_tmo, 0);
        end
        chk("R9 rx timeout flag", err_rx_tmo, 1);
        chk("R9 ready low on error", ready, 0);
        chk("R9 oe released on error", data_oe, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        bring_to_wait_rx(0); finish_rx();
        bring_to_wait_rx(1); finish_rx();
        bring_to_wait_rx(2); finish_rx();
        for (int t = 0; t < 5; t++) begin
            bring_to_wait_rx(int'($urandom % 3));
            finish_rx();
        end
        run_dir_timeout(1'b1);
        run_dir_timeout(1'b0);
        run_rx_timeout();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule